// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block turns single host transfer requests into correctly timed cycles on an 8-bit NAND flash bus. A request carries a kind (command, address, data write or data read) and a payload. The sequencer drives the latch-enable lines and the data bus. It then waits a programmed setup interval, pulses the write or read strobe low for a programmed width, and holds the bus for a programmed interval. It signals completion with a one-cycle pulse. Read bytes are captured on the final strobe-low cycle.

The three phase lengths come from configuration inputs, each holding the cycle count minus one. A parameter selects the basic variant or the extended variant. The basic variant has a 2-bit setup field and moves single bytes. The extended variant has a 3-bit setup field and moves data as 32-bit words, sent as four byte cycles with the least significant byte first. Chip enable is a sticky register bit, not pulsed per access. A low-power input forces the chip deselected and restores the bit on exit. The flash ready/busy line is synchronised into a status output.

A package function converts nanosecond phase lengths into field values for a given clock rate. A second function rejects a configuration whose phases do not fit. Both are meant for configuration code and for the bench.

Top module: `nand_strobe_seq`

## Requirements
- R1: After a request is accepted, the bus spends setup+1 cycles before the strobe, exactly width+1 cycles with the strobe low, and hold+1 cycles after it, where each value is its configuration field. `done` is high for one cycle right after the last hold cycle, with `busy` low.
- R2: The request kind is encoded as 0 = command, 1 = address, 2 = data write, 3 = data read. Through the whole access, `nand_cle` is high only for a command and `nand_ale` is high only for an address; the two are never high together.
- R3: For command, address and data-write accesses, `nand_dq_out` carries the byte and `nand_dq_oe` is high for the whole access. The strobe is `nand_we_n`, and `nand_re_n` stays high.
- R4: For a data read, `nand_re_n` is the strobe, `nand_we_n` stays high and `nand_dq_oe` stays low. The byte on `nand_dq_in` in the last strobe-low cycle is returned on `rd_data`.
- R5: In the extended variant, a data write or read moves a 32-bit word as four full byte cycles, bits 7:0 first and bits 31:24 last, with one `done` after the fourth. Commands and addresses are always one byte taken from bits 7:0.
- R6: `nand_ce_n` follows the chip-select bit: writing 1 with `sel_we` deselects (high) and writing 0 selects (low), from the next cycle. It resets to 1, and accesses do not change it.
- R7: While `sleep` is high, `nand_ce_n` is high and chip-select writes are ignored. When `sleep` falls, the bit held before sleep is restored.
- R8: `flash_ready` shows `nand_rb` (1 = ready, 0 = busy) two clock edges after it changes, and reads 0 in reset.
- R9: A request presented while `busy` is high is ignored: it causes no extra strobe, no line change and no extra `done`.
- R10: The conversion function gives floor(ns × clock_kHz / 1,000,000) + 1 cycles, never less than 1.
- R11: The timing function rejects the whole configuration when any phase exceeds its maximum. Width and hold allow up to 8 cycles. Setup allows up to 4 cycles in the basic variant and up to 8 in the extended variant. Accepted fields hold cycles minus one.
- R12: With no timing supplied, the timing function returns every phase at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_setup | input | SETUP_W | Setup cycles minus one |
| cfg_width | input | 3 | Strobe-low cycles minus one |
| cfg_hold | input | 3 | Hold cycles minus one |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_wdata | input | HDW | Payload (byte or word) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | HDW | Read result |
| sel_we | input | 1 | Chip-select bit write enable |
| sel_bit | input | 1 | Chip-select value, 1 = deselect |
| sleep | input | 1 | Low-power request |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_out | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data in |
| nand_rb | input | 1 | Ready/busy line, 1 = ready |
| flash_ready | output | 1 | Synchronised ready status |

## Verification
The assertions check on every cycle the properties that hold at any time. The two strobes are never low together, and the two latch enables are never high together. The bus is never driven while the read strobe is low. Every strobe pulse is exactly the programmed width. `done` is a lone pulse seen only when idle, and the chip is deselected during sleep. The bench scenarios are needed for the rest. They sweep all setup, width and hold combinations to check the phase lengths and the total, and they check the byte order of whole words and the data returned by reads. They also show that chip-select writes are ignored in sleep and that the bit is restored afterwards, that requests arriving while busy are dropped, and that the conversion and range-check functions give the right values.

// File: rtl/nfc_pkg.sv
// Shared types and configuration helpers for the NAND strobe sequencer.
// Assumes phase fields are three bits wide (up to eight cycles per phase).
package nfc_pkg;

    typedef enum logic [1:0] {
        NFC_CMD  = 2'd0,
        NFC_ADDR = 2'd1,
        NFC_WR   = 2'd2,
        NFC_RD   = 2'd3
    } nfc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } nfc_phase_e;

    localparam int unsigned NFC_PHASE_MAX  = 8;
    localparam int unsigned NFC_KHZ_SCALE  = 1000000;

    typedef struct packed {
        logic       ok;
        logic [2:0] setup_f;
        logic [2:0] width_f;
        logic [2:0] hold_f;
    } nfc_timing_t;

    // Nanoseconds to whole cycles, rounded up by one, at least one cycle.
    function automatic int unsigned nfc_ns_to_cycles(input int unsigned ns,
                                                     input int unsigned khz);
        longint unsigned prod;
        int unsigned     cyc;
        prod = longint'(ns) * longint'(khz);
        cyc  = int'(prod / NFC_KHZ_SCALE) + 1;
        if (cyc < 1) cyc = 1;
        return cyc;
    endfunction

    // Build the three fields; rejects the set when any phase is out of range.
    function automatic nfc_timing_t nfc_make_timing(input bit ext, input bit given,
                                                    input int unsigned ns_setup,
                                                    input int unsigned ns_width,
                                                    input int unsigned ns_hold,
                                                    input int unsigned khz);
        nfc_timing_t t;
        int unsigned smax, cs, cw, ch;
        smax = ext ? 8 : 4;
        t    = '0;
        if (!given) begin
            t.ok      = 1'b1;
            t.setup_f = 3'(smax - 1);
            t.width_f = 3'(NFC_PHASE_MAX - 1);
            t.hold_f  = 3'(NFC_PHASE_MAX - 1);
        end else begin
            cs = nfc_ns_to_cycles(ns_setup, khz);
            cw = nfc_ns_to_cycles(ns_width, khz);
            ch = nfc_ns_to_cycles(ns_hold, khz);
            if (cs <= smax && cw <= NFC_PHASE_MAX && ch <= NFC_PHASE_MAX) begin
                t.ok      = 1'b1;
                t.setup_f = 3'(cs - 1);
                t.width_f = 3'(cw - 1);
                t.hold_f  = 3'(ch - 1);
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/nfc_phase_timer.sv
// Down-counter timing one bus phase. A load sets the count; `last` is high
// in the final cycle of the phase. Assumes load values are count minus one.
module nfc_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/nfc_cs_ctl.sv
// Sticky chip-select bit with low-power override. Entering sleep saves the
// bit and forces deselect; leaving sleep restores it. Writes in sleep drop.
module nfc_cs_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_we,
    input  logic sel_bit,
    input  logic sleep,
    output logic ce_n
);
    logic sel_q, saved_q, sleep_q;

    // Track sleep edges, save/restore the bit, apply writes when awake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b1;
            saved_q <= 1'b1;
            sleep_q <= 1'b0;
        end else begin
            sleep_q <= sleep;
            if (sleep && !sleep_q) begin
                saved_q <= sel_q;
                sel_q   <= 1'b1;
            end else if (!sleep && sleep_q) begin
                sel_q   <= saved_q;
            end else if (sel_we && !sleep) begin
                sel_q   <= sel_bit;
            end
        end
    end

    assign ce_n = sel_q;
endmodule

// File: rtl/nfc_rb_sync.sv
// Two-stage synchroniser for the flash ready/busy line. Resets to busy.
module nfc_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic ready
);
    logic s1_q, s2_q;

    // Shift the line through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= rb_async;
            s2_q <= s1_q;
        end
    end

    assign ready = s2_q;
endmodule

// File: rtl/nand_strobe_seq.sv
// NAND bus strobe sequencer. Takes one request when idle and runs
// setup / strobe / hold phases per byte, then pulses done. Assumes the
// configuration fields are held stable while busy.
module nand_strobe_seq #(
    parameter bit EXT_VARIANT = 1'b0,
    localparam int SETUP_W = EXT_VARIANT ? 3 : 2,
    localparam int NBYTES  = EXT_VARIANT ? 4 : 1,
    localparam int HDW     = 8 * NBYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [2:0]         cfg_width,
    input  logic [2:0]         cfg_hold,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [HDW-1:0]     req_wdata,
    output logic               busy,
    output logic               done,
    output logic [HDW-1:0]     rd_data,
    input  logic               sel_we,
    input  logic               sel_bit,
    input  logic               sleep,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic               nand_ce_n,
    output logic [7:0]         nand_dq_out,
    output logic               nand_dq_oe,
    input  logic [7:0]         nand_dq_in,
    input  logic               nand_rb,
    output logic               flash_ready
);
    import nfc_pkg::*;

    localparam int IDXW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NBYTES - 1);

    nfc_phase_e          phase_q;
    nfc_kind_e           kind_q;
    logic [HDW-1:0]      wdata_q;
    logic [HDW-1:0]      rdata_q;
    logic [IDXW-1:0]     idx_q;
    logic                done_q;
    logic                tmr_load, tmr_last, accept, last_byte;
    logic [2:0]          tmr_val;
    logic [7:0]          cur_byte;

    assign accept    = (phase_q == PH_IDLE) && req_valid;
    assign last_byte = (kind_q == NFC_CMD) || (kind_q == NFC_ADDR) || (idx_q == LAST_IDX);
    assign cur_byte  = wdata_q[8*int'(idx_q) +: 8];

    // Choose the next phase length to load into the timer.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = 3'(cfg_setup);
        if (accept) begin
            tmr_load = 1'b1;
        end else if (phase_q != PH_IDLE && tmr_last) begin
            unique case (phase_q)
                PH_SETUP:  begin tmr_load = 1'b1; tmr_val = cfg_width; end
                PH_STROBE: begin tmr_load = 1'b1; tmr_val = cfg_hold;  end
                PH_HOLD:   begin tmr_load = !last_byte; tmr_val = 3'(cfg_setup); end
                default:   tmr_load = 1'b0;
            endcase
        end
    end

    nfc_phase_timer #(.CW(3)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    // Phase sequencing, byte stepping and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            kind_q  <= NFC_CMD;
            wdata_q <= '0;
            rdata_q <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (req_valid) begin
                    phase_q <= PH_SETUP;
                    kind_q  <= nfc_kind_e'(req_kind);
                    wdata_q <= req_wdata;
                    idx_q   <= '0;
                end
                PH_SETUP: if (tmr_last) phase_q <= PH_STROBE;
                PH_STROBE: if (tmr_last) begin
                    phase_q <= PH_HOLD;
                    if (kind_q == NFC_RD) rdata_q[8*int'(idx_q) +: 8] <= nand_dq_in;
                end
                PH_HOLD: if (tmr_last) begin
                    if (last_byte) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        phase_q <= PH_SETUP;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    nfc_cs_ctl u_cs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_we  (sel_we),
        .sel_bit (sel_bit),
        .sleep   (sleep),
        .ce_n    (nand_ce_n)
    );

    nfc_rb_sync u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nand_rb),
        .ready    (flash_ready)
    );

    assign busy        = (phase_q != PH_IDLE);
    assign done        = done_q;
    assign rd_data     = rdata_q;
    assign nand_cle    = busy && (kind_q == NFC_CMD);
    assign nand_ale    = busy && (kind_q == NFC_ADDR);
    assign nand_we_n   = !((phase_q == PH_STROBE) && (kind_q != NFC_RD));
    assign nand_re_n   = !((phase_q == PH_STROBE) && (kind_q == NFC_RD));
    assign nand_dq_oe  = busy && (kind_q != NFC_RD);
    assign nand_dq_out = nand_dq_oe ? cur_byte : 8'h00;
endmodule

// File: rtl/nfc_seq_checker.sv
// Cycle-level properties of the NAND strobe sequencer, bound to the top.
module nfc_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_width,
    input logic       busy,
    input logic       done,
    input logic       sleep,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_ce_n,
    input logic       nand_dq_oe
);
    logic       strobe_low;
    logic [3:0] run_q;

    assign strobe_low = !nand_we_n || !nand_re_n;

    // Length of the current strobe-low run.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (strobe_low) run_q <= run_q + 1'b1;
        else                 run_q <= '0;
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_low && run_q != 4'd0) |-> (run_q == {1'b0, cfg_width} + 4'd1)); // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R3
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe); // R4
    AST_SLEEP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep)) |-> nand_ce_n); // R7
endmodule

bind nand_strobe_seq nfc_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_width  (cfg_width),
    .busy       (busy),
    .done       (done),
    .sleep      (sleep),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_ce_n  (nand_ce_n),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_strobe_seq_test.sv
module nand_strobe_seq_test;
    import nfc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_setup = 3'd0, cfg_width = 3'd0, cfg_hold = 3'd0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        busy, done;
    logic [31:0] rd_data;
    logic        sel_we = 1'b0, sel_bit = 1'b1, sleep = 1'b0;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'h00;
    logic        nand_rb = 1'b1;
    logic        flash_ready;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #4 clk = ~clk;

    nand_strobe_seq #(.EXT_VARIANT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_width(cfg_width),
        .cfg_hold(cfg_hold), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .sel_we(sel_we), .sel_bit(sel_bit), .sleep(sleep), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .flash_ready(flash_ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Runs one access; measures phases and collects bus bytes.
    task automatic run_access(input logic [1:0] kind, input logic [31:0] wd,
                              input logic [31:0] rpat,
                              output int s_c, output int w_c, output int tot,
                              output int strobes, output logic [31:0] wbytes,
                              output bit bad);
        bit low, prev_low;
        s_c = 0; w_c = 0; tot = 0; strobes = 0; wbytes = '0; bad = 0; prev_low = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && tot < 400) begin
            low = !nand_we_n || !nand_re_n;
            if (low && !prev_low) begin
                if (kind != 2'd3) wbytes[8*strobes +: 8] = nand_dq_out;
                strobes++;
            end
            if (low && kind == 2'd3) nand_dq_in = rpat[8*(strobes-1) +: 8];
            if (low && strobes == 1) w_c++;
            if (!low && strobes == 0) s_c++;
            if (nand_cle != (kind == 2'd0) || nand_ale != (kind == 2'd1) ||
                nand_dq_oe != (kind != 2'd3) || !busy) bad = 1;
            if (kind == 2'd3 ? !nand_we_n : !nand_re_n) bad = 1;
            prev_low = low;
            tot++;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int s_c, w_c, tot, nstr;
        logic [31:0] wb;
        bit bad;
        nfc_timing_t t;

        repeat (3) @(negedge clk);
        // Reset state (R6, R8)
        chk(!busy && !done && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
            "reset idle R1", {busy, done, nand_we_n, nand_re_n}, 4'b0011);
        chk(nand_ce_n == 1'b1, "reset deselect R6", nand_ce_n, 1);
        chk(flash_ready == 1'b0, "reset ready R8", flash_ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(flash_ready == 1'b1, "ready after reset R8", flash_ready, 1);

        // R1 R2 R3: exhaustive phase sweep with commands
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 8; w++)
                for (int h = 0; h < 8; h++) begin
                    cfg_setup = 3'(s); cfg_width = 3'(w); cfg_hold = 3'(h);
                    run_access(2'd0, 32'(s*64 + w*8 + h), 0, s_c, w_c, tot, nstr, wb, bad);
                    chk(s_c == s+1, "setup cycles R1", s_c, s+1);
                    chk(w_c == w+1, "strobe cycles R1", w_c, w+1);
                    chk(tot == s+w+h+3, "total cycles R1", tot, s+w+h+3);
                    chk(nstr == 1 && wb[7:0] == 8'(s*64 + w*8 + h), "cmd byte R3", wb[7:0], s*64+w*8+h);
                    chk(!bad, "cmd lines R2", bad, 0);
                    chk(done && !busy, "done pulse R1", {done, busy}, 2'b10);
                end

        // R2 R5: address bytes take bits 7:0 only, single cycle
        cfg_setup = 3'd0; cfg_width = 3'd1; cfg_hold = 3'd0;
        for (int d = 0; d < 256; d++) begin
            run_access(2'd1, {24'hABCDEF, 8'(d)}, 0, s_c, w_c, tot, nstr, wb, bad);
            chk(nstr == 1 && wb[7:0] == 8'(d) && !bad, "addr byte R2 R5", wb[7:0], d);
        end

        // R3 R5: word writes, four byte cycles little-endian
        for (int k = 0; k < 24; k++) begin
            logic [31:0] pat;
            pat = 32'h1357_9BDF ^ (32'(k) * 32'h0101_1011);
            cfg_setup = 3'(k % 8); cfg_width = 3'((k * 3) % 8); cfg_hold = 3'((k * 5) % 8);
            run_access(2'd2, pat, 0, s_c, w_c, tot, nstr, wb, bad);
            chk(nstr == 4 && wb == pat, "word write order R5", wb, pat);
            chk(tot == 4*((k%8) + ((k*3)%8) + ((k*5)%8) + 3), "word total R5", tot,
                4*((k%8) + ((k*3)%8) + ((k*5)%8) + 3));
            chk(!bad, "write lines R3", bad, 0);
        end

        // R4 R5: word reads
        for (int k = 0; k < 24; k++) begin
            logic [31:0] pat;
            pat = 32'hC0DE_0000 + 32'(k * 7919);
            cfg_setup = 3'((k * 7) % 8); cfg_width = 3'(k % 8); cfg_hold = 3'((k + 2) % 8);
            run_access(2'd3, 0, pat, s_c, w_c, tot, nstr, wb, bad);
            chk(nstr == 4 && rd_data == pat, "word read R4 R5", rd_data, pat);
            chk(!bad, "read lines R4", bad, 0);
        end

        // R9: requests during busy are dropped
        begin
            int strobes_seen, dones;
            bit ale_seen, prev_low;
            cfg_setup = 3'd3; cfg_width = 3'd3; cfg_hold = 3'd3;
            strobes_seen = 0; dones = 0; ale_seen = 0; prev_low = 0;
            @(negedge clk); req_valid = 1'b1; req_kind = 2'd0; req_wdata = 32'h70;
            @(negedge clk); req_kind = 2'd1; req_wdata = 32'h55;
            for (int i = 0; i < 14; i++) begin
                if (i == 6) req_valid = 1'b0;
                if (nand_ale) ale_seen = 1;
                if (!nand_we_n && !prev_low) strobes_seen++;
                prev_low = !nand_we_n;
                if (done) dones++;
                @(negedge clk);
            end
            if (done) dones++;
            @(negedge clk);
            chk(!ale_seen && strobes_seen == 1, "busy request ignored R9", strobes_seen, 1);
            chk(dones == 1 && !busy, "single done R9", dones, 1);
        end

        // R6: chip select bit, unaffected by accesses
        @(negedge clk); sel_we = 1'b1; sel_bit = 1'b0;
        @(negedge clk); sel_we = 1'b0;
        chk(nand_ce_n == 1'b0, "select R6", nand_ce_n, 0);
        cfg_setup = 3'd1; cfg_width = 3'd1; cfg_hold = 3'd1;
        run_access(2'd0, 32'hFF, 0, s_c, w_c, tot, nstr, wb, bad);
        chk(nand_ce_n == 1'b0, "select kept across access R6", nand_ce_n, 0);
        @(negedge clk); sel_we = 1'b1; sel_bit = 1'b1;
        @(negedge clk); sel_we = 1'b0;
        chk(nand_ce_n == 1'b1, "deselect R6", nand_ce_n, 1);

        // R7: sleep forces deselect, ignores writes, restores saved bit
        for (int pre = 0; pre < 2; pre++) begin
            @(negedge clk); sel_we = 1'b1; sel_bit = 1'(pre);
            @(negedge clk); sel_we = 1'b0; sleep = 1'b1;
            @(negedge clk);
            chk(nand_ce_n == 1'b1, "sleep deselect R7", nand_ce_n, 1);
            sel_we = 1'b1; sel_bit = 1'b0;
            @(negedge clk); sel_bit = 1'b1;
            @(negedge clk); sel_we = 1'b0;
            chk(nand_ce_n == 1'b1, "sleep write ignored R7", nand_ce_n, 1);
            sleep = 1'b0;
            @(negedge clk);
            chk(nand_ce_n == 1'(pre), "sleep restore R7", nand_ce_n, pre);
        end

        // R8: ready sync latency
        @(negedge clk); nand_rb = 1'b0;
        @(negedge clk);
        chk(flash_ready == 1'b1, "ready one edge R8", flash_ready, 1);
        @(negedge clk);
        chk(flash_ready == 1'b0, "busy two edges R8", flash_ready, 0);
        nand_rb = 1'b1;
        repeat (2) @(negedge clk);
        chk(flash_ready == 1'b1, "ready back R8", flash_ready, 1);

        // R10: conversion function sweep
        for (int ns = 0; ns <= 200; ns += 5)
            for (int c = 0; c < 3; c++) begin
                int unsigned khz, exp;
                khz = (c == 0) ? 50000 : (c == 1) ? 100000 : 133000;
                exp = (ns * khz) / 1000000 + 1;
                chk(nfc_ns_to_cycles(ns, khz) == exp, "ns to cycles R10",
                    nfc_ns_to_cycles(ns, khz), exp);
            end

        // R11: range checks, both variants
        for (int sn = 0; sn <= 90; sn += 10)
            for (int wn = 0; wn <= 90; wn += 30)
                for (int e = 0; e < 2; e++) begin
                    int unsigned cs, cw, ch, smax;
                    bit okx;
                    cs = sn / 10 + 1; cw = wn / 10 + 1; ch = 3;
                    smax = e ? 8 : 4;
                    okx = (cs <= smax) && (cw <= 8);
                    t = nfc_make_timing(1'(e), 1'b1, sn, wn, 20, 100000);
                    chk(t.ok == okx, "range reject R11", t.ok, okx);
                    if (okx) chk(t.setup_f == 3'(cs-1) && t.width_f == 3'(cw-1) && t.hold_f == 3'(ch-1),
                                 "fields minus one R11", {t.setup_f, t.width_f, t.hold_f},
                                 {3'(cs-1), 3'(cw-1), 3'(ch-1)});
                end

        // R12: defaults
        t = nfc_make_timing(1'b0, 1'b0, 0, 0, 0, 100000);
        chk(t.ok && t.setup_f == 3'd3 && t.width_f == 3'd7 && t.hold_f == 3'd7,
            "default basic R12", {t.setup_f, t.width_f, t.hold_f}, {3'd3, 3'd7, 3'd7});
        t = nfc_make_timing(1'b1, 1'b0, 0, 0, 0, 100000);
        chk(t.ok && t.setup_f == 3'd7 && t.width_f == 3'd7 && t.hold_f == 3'd7,
            "default extended R12", {t.setup_f, t.width_f, t.hold_f}, {3'd7, 3'd7, 3'd7});

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule